// File: doc/BRIEF.md
# Register-Mapped Signed Integer Divider

This block is a signed integer divider that sits behind a 32-bit register bus. Software places a divisor in one register. Writing a dividend to one of two trigger registers then starts a division as a side effect of that write. One trigger runs a 32-by-32 divide. The other runs a 64-by-32 divide, whose upper dividend word is taken from a separate register written beforehand.

The divider is iterative and produces one quotient bit per clock. A `busy` output is high while it works. Results land in fixed registers only when the operation completes. The quotient and the remainder are each also copied into a second register, so either location can be read back. A zero divisor never starts an operation: the start write only stores the written value.

Results follow C truncating division. The quotient rounds toward zero, and a non-zero remainder has the sign of the dividend. When a 64-by-32 quotient does not fit in 32 bits, its low 32 bits are kept.

Top module: `sdiv_regs`

## Requirements
- R1: The divisor register at byte offset 0x100 reads back the last value written to it. All registers read as zero after reset, and `busy` is low after reset.
- R2: A write to 0x104 with a non-zero divisor starts a 32/32 signed divide of the written value. On completion the quotient appears at 0x104, 0x114 and 0x11C, and the remainder at 0x110 and 0x118.
- R3: A write to 0x114 with a non-zero divisor starts a 64/32 signed divide. The written value is the low dividend word and the contents of 0x110 are the high word. On completion the remainder appears at 0x110 and 0x118, the quotient at 0x114 and 0x11C, and 0x104 keeps its earlier value.
- R4: The quotient truncates toward zero, and the remainder is zero or carries the sign of the dividend. This holds for all four sign combinations.
- R5: When the divisor is zero, a write to 0x104 or 0x114 only stores the written value in that register. `busy` stays low and no other register changes.
- R6: `busy` rises on the clock edge that accepts a start write. It stays high for exactly 34 cycles for a 32/32 divide and 66 cycles for a 64/32 divide. The results become readable on the edge where `busy` falls.
- R7: Bus writes made while `busy` is high are ignored, to every register.
- R8: When a 64/32 quotient exceeds 32 bits, the low 32 bits of the true quotient are stored. The most negative 32-bit value divided by -1 gives 0x80000000 with remainder 0.
- R9: Any byte offset other than 0x100, 0x104, 0x110, 0x114, 0x118 and 0x11C reads as zero, and writes to it have no effect. Read data appears on `rdata` one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 9 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the cycle after `rd_en` |
| busy | output | 1 | High while a division is in progress |

## Verification
The divider is driven with small operands in all four sign combinations. These separate correct truncation toward zero from floor-style rounding, and a remainder with the dividend's sign from one with the divisor's sign. The 64/32 cases use a negative dividend that spans both words, which shows that the high word really comes from 0x110. A quotient wider than 32 bits and the most-negative-by-minus-one case expose truncation of the stored quotient. Zero-divisor starts, writes made during `busy`, and writes to an unmapped offset each check that exactly the expected registers moved. Every register is read back after each operation. This separates the 32/32 mirror pattern, where 0x104 is overwritten, from the 64/32 pattern, where it is kept.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  localparam int ADDR_W = 9;

  localparam logic [ADDR_W-1:0] OFS_DVS   = 9'h100;
  localparam logic [ADDR_W-1:0] OFS_SDVD  = 9'h104;
  localparam logic [ADDR_W-1:0] OFS_HI    = 9'h110;
  localparam logic [ADDR_W-1:0] OFS_LO    = 9'h114;
  localparam logic [ADDR_W-1:0] OFS_REM_M = 9'h118;
  localparam logic [ADDR_W-1:0] OFS_QUO_M = 9'h11C;

  typedef enum logic {MODE_SHORT = 1'b0, MODE_LONG = 1'b1} div_mode_e;
endpackage

// File: rtl/sdiv_core.sv
module sdiv_core
  import sdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  div_mode_e    mode,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] dvs,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int DW = 2 * W;
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] sh;
  logic [W-1:0]  q;
  logic [W-1:0]  r;
  logic [W-1:0]  dmag;
  logic          neg_n;
  logic          neg_q;
  logic [CW-1:0] cnt;

  // operand conditioning at start
  logic [DW-1:0] full;
  logic [DW-1:0] mag;
  logic          nn;
  logic          nd;
  logic [W-1:0]  dm;

  always_comb begin
    full = (mode == MODE_LONG) ? {dvd_hi, dvd_lo} : {{W{dvd_lo[W-1]}}, dvd_lo};
    nn   = full[DW-1];
    mag  = nn ? -full : full;
    nd   = dvs[W-1];
    dm   = nd ? -dvs : dvs;
  end

  // one restoring step
  logic [W:0]   trial;
  logic         ge;
  logic [W-1:0] r_next;

  always_comb begin
    trial  = {r, sh[DW-1]};
    ge     = trial >= {1'b0, dmag};
    r_next = ge ? (trial[W-1:0] - dmag) : trial[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      q     <= '0;
      r     <= '0;
      dmag  <= '0;
      neg_n <= 1'b0;
      neg_q <= 1'b0;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      quo   <= '0;
      rem   <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        sh    <= (mode == MODE_LONG) ? mag : {mag[W-1:0], {W{1'b0}}};
        q     <= '0;
        r     <= '0;
        dmag  <= dm;
        neg_n <= nn;
        neg_q <= nn ^ nd;
        cnt   <= (mode == MODE_LONG) ? CW'(DW) : CW'(W);
        busy  <= 1'b1;
      end else if (busy) begin
        if (cnt != '0) begin
          sh  <= {sh[DW-2:0], 1'b0};
          q   <= {q[W-2:0], ge};
          r   <= r_next;
          cnt <= cnt - 1'b1;
        end else begin
          quo  <= neg_q ? -q : q;
          rem  <= neg_n ? -r : r;
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R4: partial remainder always below the divisor magnitude
  assert_partial_rem_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != '0) |-> (r < dmag));

  // R4: a non-zero final remainder carries the dividend sign
  assert_rem_sign_R4: assert property (@(posedge clk) disable iff (rst)
    (done && rem != '0) |-> (rem[W-1] == neg_n));
endmodule

// File: rtl/sdiv_rdmux.sv
module sdiv_rdmux
  import sdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      v_dvs,
  input  logic [W-1:0]      v_sdvd,
  input  logic [W-1:0]      v_hi,
  input  logic [W-1:0]      v_lo,
  input  logic [W-1:0]      v_rem_m,
  input  logic [W-1:0]      v_quo_m,
  output logic [W-1:0]      val
);
  always_comb begin
    unique case (addr)
      OFS_DVS:   val = v_dvs;
      OFS_SDVD:  val = v_sdvd;
      OFS_HI:    val = v_hi;
      OFS_LO:    val = v_lo;
      OFS_REM_M: val = v_rem_m;
      OFS_QUO_M: val = v_quo_m;
      default:   val = '0;
    endcase
  end
endmodule

// File: rtl/sdiv_regs.sv
module sdiv_regs
  import sdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic              busy
);
  logic [W-1:0] dvs_q, sdvd_q, hi_q, lo_q, remm_q, quom_q;
  div_mode_e    mode_q;

  logic wr_ok, dvs_nz, go_short, go_long;
  assign wr_ok    = wr_en && !busy;
  assign dvs_nz   = dvs_q != '0;
  assign go_short = wr_ok && (addr == OFS_SDVD) && dvs_nz;
  assign go_long  = wr_ok && (addr == OFS_LO) && dvs_nz;

  logic         c_busy, c_done;
  logic [W-1:0] c_quo, c_rem;

  sdiv_core #(.W(W)) u_core (
    .clk    (clk),
    .rst    (rst),
    .start  (go_short || go_long),
    .mode   (go_long ? MODE_LONG : MODE_SHORT),
    .dvd_hi (hi_q),
    .dvd_lo (wdata),
    .dvs    (dvs_q),
    .busy   (c_busy),
    .done   (c_done),
    .quo    (c_quo),
    .rem    (c_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dvs_q  <= '0;
      sdvd_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      remm_q <= '0;
      quom_q <= '0;
      mode_q <= MODE_SHORT;
      busy   <= 1'b0;
    end else if (c_done) begin
      busy   <= 1'b0;
      hi_q   <= c_rem;
      remm_q <= c_rem;
      lo_q   <= c_quo;
      quom_q <= c_quo;
      if (mode_q == MODE_SHORT) sdvd_q <= c_quo;
    end else if (wr_ok) begin
      unique case (addr)
        OFS_DVS:   dvs_q  <= wdata;
        OFS_SDVD:  sdvd_q <= wdata;
        OFS_HI:    hi_q   <= wdata;
        OFS_LO:    lo_q   <= wdata;
        OFS_REM_M: remm_q <= wdata;
        OFS_QUO_M: quom_q <= wdata;
        default: ;
      endcase
      if (go_short || go_long) begin
        busy   <= 1'b1;
        mode_q <= go_long ? MODE_LONG : MODE_SHORT;
      end
    end
  end

  logic [W-1:0] rd_val;

  sdiv_rdmux #(.W(W)) u_rdmux (
    .addr    (addr),
    .v_dvs   (dvs_q),
    .v_sdvd  (sdvd_q),
    .v_hi    (hi_q),
    .v_lo    (lo_q),
    .v_rem_m (remm_q),
    .v_quo_m (quom_q),
    .val     (rd_val)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  // R6: an accepted start raises busy
  assert_start_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (go_short || go_long) |=> busy);

  // R6: the core is running whenever the block reports busy, except the hand-off cycle
  assert_core_run_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !c_done) |-> c_busy);

  // R5: a zero divisor never starts an operation
  assert_zero_div_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && (addr == OFS_SDVD || addr == OFS_LO) && !dvs_nz) |=> !busy);

  // R7: the divisor cannot change while an operation runs
  assert_dvs_hold_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(dvs_q));

  // R2 and R3: the mirror copies match on completion
  assert_mirror_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (remm_q == hi_q && quom_q == lo_q));

  // R2: a short divide also places the quotient at 0x104
  assert_short_quo_R2: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && mode_q == MODE_SHORT) |-> (sdvd_q == lo_q));

  // R3: a long divide leaves 0x104 untouched
  assert_long_keep_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && mode_q == MODE_LONG) |-> $stable(sdvd_q));
endmodule

// File: tb/sim_sdiv_regs.sv
`timescale 1ns/1ps
module sim_sdiv_regs;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [8:0]  addr;
  logic [31:0] wdata, rdata;
  logic        busy;

  always #10 clk = ~clk;

  sdiv_regs u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
  );

  typedef struct {
    logic [8:0]  a;
    logic [31:0] e;
    string       tag;
  } exp_t;

  exp_t q_exp[$];
  int   errs = 0;
  int   checks = 0;
  logic rd_seen = 1'b0;
  bit   ended = 1'b0;

  logic [31:0] m100, m104, m110, m114, m118, m11c;

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: pops expected read results as rdata becomes valid
  always @(negedge clk) begin
    if (rd_seen) begin
      checks++;
      if (q_exp.size() == 0) begin
        errs++;
        $display("FAIL scoreboard empty: act=%h exp=none", rdata);
      end else begin
        exp_t it;
        it = q_exp.pop_front();
        if (rdata !== it.e) begin
          errs++;
          $display("FAIL %s @%h: act=%h exp=%h", it.tag, it.a, rdata, it.e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: act=timeout exp=finish");
    finish_run();
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [8:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    it.a = a; it.e = e; it.tag = tag;
    q_exp.push_back(it);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check_all(input string tag);
    rd_chk(9'h100, m100, tag);
    rd_chk(9'h104, m104, tag);
    rd_chk(9'h110, m110, tag);
    rd_chk(9'h114, m114, tag);
    rd_chk(9'h118, m118, tag);
    rd_chk(9'h11C, m11c, tag);
    @(negedge clk);
  endtask

  // driver: updates the model, issues the start write, measures busy
  task automatic run_div(input bit is_long, input logic [31:0] d, input string tag);
    longint a, dv, qq, rr;
    int n;
    int exp_n;
    dv = longint'(signed'(m100));
    if (is_long) a = longint'({m110, d});
    else         a = longint'(signed'(d));
    if (m100 != 0) begin
      qq = a / dv;
      rr = a % dv;
      if (!is_long) m104 = qq[31:0];
      m114 = qq[31:0]; m11c = qq[31:0];
      m110 = rr[31:0]; m118 = rr[31:0];
      exp_n = is_long ? 66 : 34;
    end else begin
      if (is_long) m114 = d; else m104 = d;
      exp_n = 0;
    end
    wr(is_long ? 9'h114 : 9'h104, d);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    chk(n == exp_n, {tag, " R6 busy length"}, 32'(n), 32'(exp_n));
    check_all(tag);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    m100 = 0; m104 = 0; m110 = 0; m114 = 0; m118 = 0; m11c = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(busy == 1'b0, "R1 busy after reset", 32'(busy), 32'd0);
    check_all("R1 reset value");

    // R1 divisor readback
    wr(9'h100, 32'd7); m100 = 32'd7;
    check_all("R1 divisor readback");

    // R2 short divide, R4 signs
    run_div(1'b0, 32'd100, "R2 short 100/7");
    run_div(1'b0, -32'sd100, "R4 short -100/7");
    wr(9'h100, -32'sd7); m100 = -32'sd7;
    run_div(1'b0, 32'd100, "R4 short 100/-7");
    run_div(1'b0, -32'sd100, "R4 short -100/-7");

    // R8 most negative by -1
    wr(9'h100, 32'hFFFF_FFFF); m100 = 32'hFFFF_FFFF;
    run_div(1'b0, 32'h8000_0000, "R8 short min/-1");

    // R3 long divide with negative dividend spanning both words
    wr(9'h100, 32'd7); m100 = 32'd7;
    run_div(1'b0, 32'd50, "R2 short 50/7 before long");
    wr(9'h110, 32'hFFFF_FFFF); m110 = 32'hFFFF_FFFF;
    run_div(1'b1, 32'hFFFF_FC18, "R3 long -1000/7");
    wr(9'h110, 32'h0000_0002); m110 = 32'h0000_0002;
    run_div(1'b1, 32'h0000_0001, "R3 long (2^33+1)/7");

    // R8 quotient wider than 32 bits
    wr(9'h100, 32'd2); m100 = 32'd2;
    wr(9'h110, 32'd3); m110 = 32'd3;
    run_div(1'b1, 32'd7, "R8 long wide quotient");

    // R5 zero divisor
    wr(9'h100, 32'd0); m100 = 32'd0;
    run_div(1'b0, 32'd55, "R5 zero divisor short");
    run_div(1'b1, 32'd9, "R5 zero divisor long");

    // R7 writes during busy
    wr(9'h100, 32'd10); m100 = 32'd10;
    wr(9'h104, 32'd1234);
    m104 = 32'd123; m114 = 32'd123; m11c = 32'd123; m110 = 32'd4; m118 = 32'd4;
    chk(busy == 1'b1, "R6 busy after start", 32'(busy), 32'd1);
    wr(9'h100, 32'd3);
    wr(9'h118, 32'h0000_00AA);
    wr(9'h110, 32'h5555_5555);
    while (busy) @(negedge clk);
    check_all("R7 writes ignored while busy");

    // R9 unmapped offset
    wr(9'h108, 32'hDEAD_BEEF);
    rd_chk(9'h108, 32'd0, "R9 unmapped reads zero");
    rd_chk(9'h106, 32'd0, "R9 misaligned reads zero");
    check_all("R9 unmapped write has no effect");

    repeat (4) @(negedge clk);
    chk(q_exp.size() == 0, "scoreboard drained", 32'(q_exp.size()), 32'd0);
    finish_run();
  end
endmodule